// File: doc/BRIEF.md
# Concatenable dual PWM channel pair

This block holds two left-aligned pulse-width modulators that share one runtime mode bit. With the mode bit low, each channel runs by itself. Each channel has an 8-bit period value, an 8-bit duty value, a counter and an output pin. The counter steps on an enable tick taken from one of two prescaled tick inputs, and a per-channel select input picks which one. With the mode bit high, the two channels act as one 16-bit modulator. Channel 1 supplies the upper byte of the counter, the period and the duty, and channel 2 supplies the lower byte. The waveform then leaves on the channel 2 pin, and the channel 1 pin stays low.

A two-state mode machine tracks the bit. Its states are `MODE_SPLIT` (separate channels, the reset state) and `MODE_JOIN` (one 16-bit channel). The transition `T_JOIN` leads from `MODE_SPLIT` to `MODE_JOIN` when the mode input is 1. The transition `T_SPLIT` leads from `MODE_JOIN` to `MODE_SPLIT` when the mode input is 0. Each transition clears both counters in the same clock edge, so both modes always start from a zero count. The tick inputs come from an external prescaler, and the period and duty values are held by an external register bank.

Top module: `pwmpair_top`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first sample after it drops, both outputs are low or follow zero counters. The mode is split.
- R2: In split mode, channel 1's counter advances by one on each selected tick and wraps to 0 on a tick taken when it is at or above `per1_i`. `pwm1_o` is 1 exactly while counter < `duty1_i`. A period is therefore `per1_i`+1 ticks, with `duty1_i` ticks high.
- R3: In split mode, channel 2 behaves the same way with `per2_i`, `duty2_i` and `pwm2_o`, independently of channel 1.
- R4: The select input `sel1_i` / `sel2_i` chooses the tick: 0 picks `tick_a_i` and 1 picks `tick_b_i`.
- R5: A counter holds its value in every cycle without its selected tick.
- R6: In joined mode, the 16-bit count {counter1, counter2} is compared with {`per1_i`,`per2_i`} and {`duty1_i`,`duty2_i`}. The counter wraps after reaching the period, and the output on `pwm2_o` is high while count < duty.
- R7: In joined mode, `pwm1_o` is held low.
- R8: In joined mode, only `sel2_i` chooses the tick for the combined counter. `sel1_i` has no effect.
- R9: The first clock edge at which `cat_i` differs from the current mode switches the mode and clears both counters to zero.
- R10: A duty value above the period keeps the output high for the whole period. A duty of zero keeps it low.
- R11: If the period is lowered below the current count, the next tick wraps the counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cat_i | input | 1 | 1 joins the channels into one 16-bit PWM |
| tick_a_i | input | 1 | Prescaled enable tick A |
| tick_b_i | input | 1 | Prescaled enable tick B |
| sel1_i | input | 1 | Channel 1 tick select (0 = A, 1 = B) |
| sel2_i | input | 1 | Channel 2 tick select (0 = A, 1 = B) |
| per1_i | input | 8 | Channel 1 period (high byte when joined) |
| duty1_i | input | 8 | Channel 1 duty (high byte when joined) |
| per2_i | input | 8 | Channel 2 period (low byte when joined) |
| duty2_i | input | 8 | Channel 2 duty (low byte when joined) |
| pwm1_o | output | 1 | Channel 1 output, low when joined |
| pwm2_o | output | 1 | Channel 2 output, carries the 16-bit waveform when joined |

## Verification
The outputs are combinational compares of the counters, so a wrong count appears on a pin in the same cycle the counter goes wrong. This holds whenever the faulty value lies on the other side of the duty threshold. A fault that stays on the same side, such as an early wrap or a lost carry into the upper byte, stays hidden until the count crosses the duty value or the period. That can take up to a full period, so the bench runs every scenario over whole periods. It compares each cycle against a count model and tallies the high cycles per period. A wrong mode state shows at once as activity on `pwm1_o` in joined mode, or as a missing clear after a change of `cat_i`.

// File: rtl/pwmpair_pkg.sv
package pwmpair_pkg;
    typedef enum logic [0:0] {
        MODE_SPLIT = 1'b0,
        MODE_JOIN  = 1'b1
    } mode_e;
endpackage

// File: rtl/pwmpair_tick_sel.sv
module pwmpair_tick_sel (
    input  logic tick_a,
    input  logic tick_b,
    input  logic sel,
    output logic tick
);
    always_comb begin
        tick = sel ? tick_b : tick_a;
    end
endmodule

// File: rtl/pwmpair_mode_fsm.sv
module pwmpair_mode_fsm
    import pwmpair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cat,
    output mode_e mode,
    output logic  clr
);
    mode_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_SPLIT;
        else     state_q <= state_d;
    end

    // Next state: T_JOIN and T_SPLIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SPLIT: if (cat)  state_d = MODE_JOIN;
            MODE_JOIN:  if (!cat) state_d = MODE_SPLIT;
            default:    state_d = MODE_SPLIT;
        endcase
    end

    // Outputs: a taken transition clears the counters
    always_comb begin
        mode = state_q;
        clr  = 1'b0;
        unique case (state_q)
            MODE_SPLIT: clr = cat;
            MODE_JOIN:  clr = !cat;
            default:    clr = 1'b1;
        endcase
    end

    // R9: the state never stays behind a different mode request
    a_r9_mode_follows: assert property (@(posedge clk) disable iff (rst)
        (cat != (state_q == MODE_JOIN)) |=> (state_q == ($past(cat) ? MODE_JOIN : MODE_SPLIT)));
endmodule

// File: rtl/pwmpair_core.sv
module pwmpair_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         joined,
    input  logic         clr,
    input  logic         en1,
    input  logic         en2,
    input  logic [W-1:0] per1,
    input  logic [W-1:0] duty1,
    input  logic [W-1:0] per2,
    input  logic [W-1:0] duty2,
    output logic         pwm1,
    output logic         pwm2
);
    localparam int JW = 2 * W;
    localparam logic [W-1:0]  ONE_W = 1;
    localparam logic [JW-1:0] ONE_J = 1;

    logic [W-1:0]  c1_q, c2_q, c1_n, c2_n;
    logic [JW-1:0] jcnt, jper, jduty, jcnt_n;

    always_comb begin
        jcnt   = {c1_q, c2_q};
        jper   = {per1, per2};
        jduty  = {duty1, duty2};
        c1_n   = (c1_q >= per1) ? '0 : c1_q + ONE_W;
        c2_n   = (c2_q >= per2) ? '0 : c2_q + ONE_W;
        jcnt_n = (jcnt >= jper) ? '0 : jcnt + ONE_J;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            c1_q <= '0;
            c2_q <= '0;
        end else if (joined) begin
            if (en2) {c1_q, c2_q} <= jcnt_n;
        end else begin
            if (en1) c1_q <= c1_n;
            if (en2) c2_q <= c2_n;
        end
    end

    always_comb begin
        pwm1 = !joined && (c1_q < duty1);
        pwm2 = joined ? (jcnt < jduty) : (c2_q < duty2);
    end

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (c1_q == '0 && c2_q == '0));
    a_r5_hold_split: assert property (@(posedge clk) disable iff (rst)
        (!joined && !clr && !en1) |=> $stable(c1_q));
    a_r11_wrap_split: assert property (@(posedge clk) disable iff (rst)
        (!joined && !clr && en1 && c1_q >= per1) |=> (c1_q == '0));
    a_r6_join_step: assert property (@(posedge clk) disable iff (rst)
        (joined && !clr && en2 && jcnt < jper) |=> (jcnt == $past(jcnt) + ONE_J));
endmodule

// File: rtl/pwmpair_top.sv
module pwmpair_top
    import pwmpair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cat_i,
    input  logic         tick_a_i,
    input  logic         tick_b_i,
    input  logic         sel1_i,
    input  logic         sel2_i,
    input  logic [W-1:0] per1_i,
    input  logic [W-1:0] duty1_i,
    input  logic [W-1:0] per2_i,
    input  logic [W-1:0] duty2_i,
    output logic         pwm1_o,
    output logic         pwm2_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] sel_v, en_v;
    mode_e          mode;
    logic           clr;

    assign sel_v = {sel2_i, sel1_i};

    for (genvar g = 0; g < NCH; g++) begin : g_tick
        pwmpair_tick_sel u_sel (
            .tick_a (tick_a_i),
            .tick_b (tick_b_i),
            .sel    (sel_v[g]),
            .tick   (en_v[g])
        );
    end

    pwmpair_mode_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .cat  (cat_i),
        .mode (mode),
        .clr  (clr)
    );

    pwmpair_core #(.W(W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .joined (mode == MODE_JOIN),
        .clr    (clr),
        .en1    (en_v[0]),
        .en2    (en_v[1]),
        .per1   (per1_i),
        .duty1  (duty1_i),
        .per2   (per2_i),
        .duty2  (duty2_i),
        .pwm1   (pwm1_o),
        .pwm2   (pwm2_o)
    );

    a_r7_pin1_low: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_JOIN) |-> !pwm1_o);
    a_r10_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SPLIT && duty2_i == '0) |-> !pwm2_o);
endmodule

// File: tb/sim_pwmpair_top.sv
module sim_pwmpair_top;
    logic clk = 1'b0, rst = 1'b1, cat = 1'b0;
    logic tick_a = 1'b0, tick_b = 1'b0, sel1 = 1'b0, sel2 = 1'b0;
    logic [7:0] per1 = 8'd0, duty1 = 8'd0, per2 = 8'd0, duty2 = 8'd0;
    logic pwm1, pwm2;
    int n_chk = 0, n_bad = 0;
    int div_a = 1, div_b = 1;   // 0 = tick never fires
    int cyc = 0;

    // reference count model
    logic [7:0] m1 = 8'd0, m2 = 8'd0;
    logic       mj = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pwmpair_top u0 (
        .clk(clk), .rst(rst), .cat_i(cat), .tick_a_i(tick_a), .tick_b_i(tick_b),
        .sel1_i(sel1), .sel2_i(sel2), .per1_i(per1), .duty1_i(duty1),
        .per2_i(per2), .duty2_i(duty2), .pwm1_o(pwm1), .pwm2_o(pwm2)
    );

    // ticks driven away from the active edge
    always @(negedge clk) begin
        cyc++;
        tick_a <= (div_a != 0) && (cyc % (div_a == 0 ? 1 : div_a) == 0);
        tick_b <= (div_b != 0) && (cyc % (div_b == 0 ? 1 : div_b) == 0);
    end

    always @(posedge clk) begin
        logic [15:0] j;
        logic t1, t2;
        t1 = sel1 ? tick_b : tick_a;
        t2 = sel2 ? tick_b : tick_a;
        if (rst) begin
            m1 = 0; m2 = 0; mj = 0;
        end else if (cat != mj) begin
            m1 = 0; m2 = 0; mj = cat;
        end else if (mj) begin
            if (t2) begin
                j = {m1, m2};
                j = (j >= {per1, per2}) ? 16'd0 : j + 16'd1;
                {m1, m2} = j;
            end
        end else begin
            if (t1) m1 = (m1 >= per1) ? 8'd0 : m1 + 8'd1;
            if (t2) m2 = (m2 >= per2) ? 8'd0 : m2 + 8'd1;
        end
    end

    function automatic logic exp1();
        return !mj && (m1 < duty1);
    endfunction
    function automatic logic exp2();
        return mj ? ({m1, m2} < {duty1, duty2}) : (m2 < duty2);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cat = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // compare against model over n cycles; count highs
    task automatic run(input int n, output int miss, output int hi1, output int hi2);
        miss = 0; hi1 = 0; hi2 = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (pwm1 !== exp1() || pwm2 !== exp2()) miss++;
            hi1 += int'(pwm1);
            hi2 += int'(pwm2);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int miss, h1, h2;
        @(negedge clk); rst = 1'b1; per1 = 8'd9; duty1 = 8'd3; per2 = 8'd4; duty2 = 8'd2;
        @(negedge clk); @(negedge clk); #1;
        chk("R1 pwm1 high from zero count in reset", int'(pwm1), 1);
        chk("R1 pwm2 high from zero count in reset", int'(pwm2), 1);
        duty1 = 8'd0; duty2 = 8'd0; #1;
        chk("R1 pwm1 low with zero duty in reset", int'(pwm1), 0);
        rst = 1'b0; duty1 = 8'd3; duty2 = 8'd2;
        run(1, miss, h1, h2);
        chk("R1 first sample after reset", miss, 0);
    endtask

    task automatic t_split();
        int miss, h1, h2;
        per1 = 8'd9; duty1 = 8'd3; sel1 = 1'b0; div_a = 1;
        per2 = 8'd4; duty2 = 8'd2; sel2 = 1'b1; div_b = 2;
        do_reset();
        run(100, miss, h1, h2);
        chk("R2/R3 model compare split", miss, 0);
        chk("R2 ch1 high cycles 3 of 10", h1, 30);
        chk("R3 R4 ch2 on tick B high 4 of 10", h2, 40);
        sel1 = 1'b1; sel2 = 1'b0; div_b = 3;
        run(90, miss, h1, h2);
        chk("R4 swapped selects model compare", miss, 0);
        chk("R4 ch2 on tick A high 2 of 5", h2, 36);
    endtask

    task automatic t_hold();
        int miss, h1, h2;
        per2 = 8'd9; duty2 = 8'd5; sel2 = 1'b1; div_b = 1;
        do_reset();
        run(3, miss, h1, h2);
        div_b = 0; @(negedge clk);
        run(40, miss, h1, h2);
        chk("R5 held counter model compare", miss, 0);
        chk("R5 ch2 stays high while held at 3/4", h2, 40);
    endtask

    task automatic t_join();
        int miss, h1, h2;
        per1 = 8'd1; per2 = 8'd3; duty1 = 8'd0; duty2 = 8'd200;
        sel2 = 1'b0; div_a = 1; sel1 = 1'b1; div_b = 0;
        do_reset();
        cat = 1'b1; @(negedge clk);
        run(520, miss, h1, h2);
        chk("R6 R8 joined model compare", miss, 0);
        chk("R6 joined pwm2 high 200 of 260", h2, 400);
        chk("R7 pwm1 low when joined", h1, 0);
        sel1 = 1'b0; div_b = 1; duty1 = 8'd1; duty2 = 8'd0;
        run(260, miss, h1, h2);
        chk("R8 sel1 ignored, duty 256 of 260", h2, 256);
        chk("R8 pwm1 still low", h1, 0);
    endtask

    task automatic t_modechg();
        int miss, h1, h2;
        per1 = 8'd9; duty1 = 8'd1; sel1 = 1'b0; div_a = 1;
        per2 = 8'd9; duty2 = 8'd1; sel2 = 1'b0;
        cat = 1'b0; @(negedge clk); @(negedge clk);
        run(5, miss, h1, h2);
        cat = 1'b1; @(negedge clk); #1;
        chk("R9 joined count cleared -> pwm2 high", int'(pwm2), 1);
        chk("R9 pwm1 low after join", int'(pwm1), 0);
        run(4, miss, h1, h2);
        cat = 1'b0; @(negedge clk); #1;
        chk("R9 split count cleared -> pwm1 high", int'(pwm1), 1);
        @(negedge clk); #1;
        chk("R9 count restarts at 1 -> pwm1 low", int'(pwm1), 0);
    endtask

    task automatic t_edges();
        int miss, h1, h2;
        per1 = 8'd5; duty1 = 8'd20; per2 = 8'd5; duty2 = 8'd0;
        sel1 = 1'b0; sel2 = 1'b0; div_a = 1;
        do_reset();
        run(60, miss, h1, h2);
        chk("R10 duty above period always high", h1, 60);
        chk("R10 zero duty always low", h2, 0);
    endtask

    task automatic t_shrink();
        int miss, h1, h2;
        per1 = 8'd200; duty1 = 8'd1; sel1 = 1'b0; div_a = 1;
        do_reset();
        run(100, miss, h1, h2);
        per1 = 8'd10; @(negedge clk); #1;
        chk("R11 wrap to 0 after period lowered", int'(pwm1), 1);
        run(22, miss, h1, h2);
        chk("R11 model compare after shrink", miss, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_split();
                t_hold();
                t_join();
                t_modechg();
                t_edges();
                t_shrink();
            end
            begin
                repeat (20000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule